// File: doc/BRIEF.md
# Fractional-Rate Time-of-Day Counter

This block keeps a free-running nanosecond time of day for a network timestamping unit. It runs from a reference whose ticks are 8 ns apart. Each tick advances the count by a fixed 8 ns. A signed trim word adjusts the effective rate by adding or subtracting a sub-nanosecond amount to a 32-bit residue accumulator. Whenever that accumulator overflows or underflows, the tick's step is stretched or shortened by one nanosecond.

Software uses a small register port. A read of the residue word freezes a copy of the whole time value, and the low and high nanosecond words are then read from that copy. For writes, the residue and low words are staged first. The write of the high word then loads all three at once. A halt bit in a control word stops the counter, and it resets to the halted state.

Top module: `tod_timer`

## Requirements
- R1: With a zero trim word, each cycle with `tick` high and the counter running advances the nanosecond count by exactly 8, with the residue unchanged.
- R2: The trim word (address 3) holds a 31-bit magnitude in bits 30:0 in units of 2^-32 ns and a sign in bit 31. Sign clear adds the magnitude to the residue on every tick; sign set subtracts it. The residue wraps modulo 2^32.
- R3: A residue overflow on an adding tick makes that tick's step 9 ns. A residue underflow on a subtracting tick makes it 7 ns.
- R4: The nanosecond count is 40 bits wide. Bits 31:0 sit at address 1 and bits 39:32 at bits 7:0 of address 2. Bits 31:8 of address 2 always read zero, and only bits 7:0 of a write to address 2 are used.
- R5: The nanosecond count wraps modulo 2^40, carrying from the low word into the high word.
- R6: A read of address 0 returns the live residue and copies the full time value. Later reads of addresses 1 and 2 return that copy, however far the counter has moved since.
- R7: Writes to address 0 (residue) and address 1 (low word) only stage values and leave the running count untouched. A write to address 2 loads the staged residue, the staged low word and the written high bits together in one cycle.
- R8: Control word bit 31 (address 4) halts the counter and residue while it is set. It resets to 1, and writing 0 there lets the counter run.
- R9: A new trim word is first used on the tick in the cycle after its write. A tick in the same cycle as the write uses the old trim word.
- R10: Reset clears the count, residue, trim word, copy and staging. Read data appears on `reg_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One 8 ns reference tick per high cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 residue, 1 low, 2 high, 3 trim, 4 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
The bench sets a start time and a trim word, runs a fixed number of ticks and compares the residue and both count words with hand-computed values. It targets four faults:
- Residue carry or borrow: an accumulator that ignores its carry, or treats a borrow as a carry, ends off by a few nanoseconds.
- Low-to-high carry: a count that does not carry from the low word into the high word at 2^32, or does not wrap at 2^40, shows a wrong high word.
- Snapshot and staging: the bench reads after more ticks have passed, and writes the low word ahead of the high word. A design that reads live values or loads staged words early fails these checks.
- Trim-word timing: a tick issued in the same cycle as a trim write must still use the old value.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DATA_W  = 32;
    localparam int NS_W    = 40;
    localparam int FRAC_W  = 32;
    localparam int STEP_NS = 8;
    localparam int HI_W    = NS_W - DATA_W;

    typedef enum logic [2:0] {
        RA_RESID = 3'd0,
        RA_NS_LO = 3'd1,
        RA_NS_HI = 3'd2,
        RA_RATE  = 3'd3,
        RA_CTRL  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              neg;
        logic [FRAC_W-2:0] mag;
    } rate_t;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        logic              carry;
        logic              borrow;
        logic [FRAC_W-1:0] frac;
    } acc_res_t;

    function automatic acc_res_t frac_step(input logic [FRAC_W-1:0] f, input rate_t r);
        logic [FRAC_W:0] s;
        acc_res_t        o;
        if (r.neg) begin
            s        = {1'b0, f} - {2'b00, r.mag};
            o.carry  = 1'b0;
            o.borrow = s[FRAC_W];
        end else begin
            s        = {1'b0, f} + {2'b00, r.mag};
            o.carry  = s[FRAC_W];
            o.borrow = 1'b0;
        end
        o.frac = s[FRAC_W-1:0];
        return o;
    endfunction

    function automatic logic [NS_W-1:0] ns_step(input logic carry, input logic borrow);
        return NS_W'(STEP_NS) + NS_W'(carry) - NS_W'(borrow);
    endfunction
endpackage

// File: rtl/tod_frac_acc.sv
module tod_frac_acc
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              load,
    input  logic [FRAC_W-1:0] load_frac,
    input  rate_t             rate,
    output logic [FRAC_W-1:0] frac_q,
    output logic              carry,
    output logic              borrow
);
    acc_res_t res;

    always_comb begin
        res    = frac_step(frac_q, rate);
        carry  = step & res.carry;
        borrow = step & res.borrow;
    end

    always_ff @(posedge clk) begin
        if (rst)       frac_q <= '0;
        else if (load) frac_q <= load_frac;
        else if (step) frac_q <= res.frac;
    end

    AST_ZERO_RATE_FRAC: assert property (@(posedge clk) disable iff (rst)
        (step && !load && rate.mag == '0) |=> $stable(frac_q)); // R2
endmodule

// File: rtl/tod_ns_ctr.sv
module tod_ns_ctr
    import tod_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            carry,
    input  logic            borrow,
    input  logic            load,
    input  logic [NS_W-1:0] load_ns,
    output logic [NS_W-1:0] ns_q
);
    always_ff @(posedge clk) begin
        if (rst)       ns_q <= '0;
        else if (load) ns_q <= load_ns;
        else if (step) ns_q <= ns_q + ns_step(carry, borrow);
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (((ns_q - $past(ns_q)) >= NS_W'(STEP_NS - 1)) &&
                             ((ns_q - $past(ns_q)) <= NS_W'(STEP_NS + 1)))); // R3
endmodule

// File: rtl/tod_regport.sv
module tod_regport
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  tod_t              live,
    output rate_t             rate_q,
    output logic              halt_q,
    output logic              load,
    output tod_t              load_val,
    output logic [DATA_W-1:0] rdata
);
    reg_addr_e         ra;
    tod_t              snap_q;
    tod_t              stage_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        ra       = reg_addr_e'(addr);
        load     = wr && (ra == RA_NS_HI);
        load_val = '{ns: {wdata[HI_W-1:0], stage_q.ns[DATA_W-1:0]}, frac: stage_q.frac};
        case (ra)
            RA_RESID: rd_mux = live.frac;
            RA_NS_LO: rd_mux = snap_q.ns[DATA_W-1:0];
            RA_NS_HI: rd_mux = DATA_W'(snap_q.ns[NS_W-1:DATA_W]);
            RA_RATE:  rd_mux = rate_q;
            RA_CTRL:  rd_mux = {halt_q, {(DATA_W-1){1'b0}}};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            stage_q <= '0;
            rate_q  <= '0;
            halt_q  <= 1'b1;
            rdata   <= '0;
        end else begin
            if (wr) begin
                case (ra)
                    RA_RESID: stage_q.frac             <= wdata;
                    RA_NS_LO: stage_q.ns[DATA_W-1:0]   <= wdata;
                    RA_NS_HI: stage_q.ns[NS_W-1:DATA_W] <= wdata[HI_W-1:0];
                    RA_RATE:  rate_q                   <= rate_t'(wdata);
                    RA_CTRL:  halt_q                   <= wdata[DATA_W-1];
                    default: ;
                endcase
            end
            if (rd) begin
                rdata <= rd_mux;
                if (ra == RA_RESID) snap_q <= live;
            end
        end
    end

    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 3'd2) |=> (rdata[DATA_W-1:HI_W] == '0)); // R4
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == 3'd0) |=> $stable(snap_q)); // R6
endmodule

// File: rtl/tod_timer.sv
module tod_timer
    import tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    rate_t             rate_q;
    logic              halt_q;
    logic              load;
    tod_t              load_val;
    tod_t              live;
    logic              run;
    logic              step;
    logic              carry;
    logic              borrow;
    logic [NS_W-1:0]   ns_q;
    logic [FRAC_W-1:0] frac_q;

    assign run  = tick & ~halt_q;
    assign step = run & ~load;
    assign live = '{ns: ns_q, frac: frac_q};

    tod_regport u_port (
        .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .live(live), .rate_q(rate_q), .halt_q(halt_q),
        .load(load), .load_val(load_val), .rdata(reg_rdata)
    );

    tod_frac_acc u_acc (
        .clk(clk), .rst(rst), .step(step), .load(load), .load_frac(load_val.frac),
        .rate(rate_q), .frac_q(frac_q), .carry(carry), .borrow(borrow)
    );

    tod_ns_ctr u_ns (
        .clk(clk), .rst(rst), .step(step), .carry(carry), .borrow(borrow),
        .load(load), .load_ns(load_val.ns), .ns_q(ns_q)
    );

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !load) |=> ($stable(ns_q) && $stable(frac_q))); // R8
    AST_STAGED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != 3'd2 && !run) |=> ($stable(ns_q) && $stable(frac_q))); // R7
endmodule

// File: tb/tod_timer_test.sv
`timescale 1ns/1ps
module tod_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tod_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [39:0] start_ns;
        logic [31:0] start_frac;
        logic [31:0] rate;
        logic [15:0] n;
        logic [39:0] exp_ns;
        logic [31:0] exp_frac;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{40'd0,             32'h0,        32'h0,        16'd10, 40'd80,            32'h0},        // R1
        '{40'd0,             32'h0,        32'h40000000, 16'd8,  40'd66,            32'h0},        // R2 R3 carry
        '{40'd0,             32'h0,        32'hC0000000, 16'd8,  40'd62,            32'h0},        // R2 R3 borrow
        '{40'd0,             32'h0,        32'h00000001, 16'd5,  40'd40,            32'h5},        // R2
        '{40'd0,             32'h0,        32'h7FFFFFFF, 16'd3,  40'd25,            32'h7FFFFFFD}, // R3
        '{40'd0,             32'h0,        32'h80000001, 16'd2,  40'd15,            32'hFFFFFFFE}, // R3
        '{40'hFF_FFFF_FFF8,  32'h0,        32'h0,        16'd2,  40'd8,             32'h0},        // R5 wrap
        '{40'd100,           32'hFFFFFFFF, 32'h1,        16'd1,  40'd109,           32'h0},        // R3
        '{40'h00_FFFF_FFFC,  32'h0,        32'h0,        16'd1,  40'h01_0000_0004,  32'h0}         // R5 carry to high
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_time(input logic [39:0] ns, input logic [31:0] frac);
        wr(3'd0, frac);
        wr(3'd1, ns[31:0]);
        wr(3'd2, {24'd0, ns[39:32]});
    endtask

    task automatic read_time(output logic [31:0] f, output logic [31:0] lo, output logic [31:0] hi);
        rd(3'd0, f);
        rd(3'd1, lo);
        rd(3'd2, hi);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] f, lo, hi, d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 / R8: reset state
        rd(3'd4, d);  check("R8 ctrl reset halted", d, 32'h80000000);
        rd(3'd3, d);  check("R10 rate reset", d, 32'h0);
        read_time(f, lo, hi);
        check("R10 residue reset", f, 32'h0);
        check("R10 low reset", lo, 32'h0);
        check("R10 high reset", hi, 32'h0);

        // R8: halted after reset, ticks ignored
        run_ticks(5);
        read_time(f, lo, hi);
        check("R8 halted low", lo, 32'h0);
        wr(3'd4, 32'h0);

        // vector table: R1 R2 R3 R5
        for (int i = 0; i < NV; i++) begin
            wr(3'd3, VECS[i].rate);
            load_time(VECS[i].start_ns, VECS[i].start_frac);
            run_ticks(int'(VECS[i].n));
            read_time(f, lo, hi);
            check($sformatf("R1/R2/R3/R5 vec%0d residue", i), f, VECS[i].exp_frac);
            check($sformatf("R1/R3/R5 vec%0d low", i), lo, VECS[i].exp_ns[31:0]);
            check($sformatf("R4/R5 vec%0d high", i), hi, {24'd0, VECS[i].exp_ns[39:32]});
        end

        // R6: snapshot held across ticks
        wr(3'd3, 32'h0);
        load_time(40'd0, 32'h0);
        rd(3'd0, f);
        run_ticks(5);
        rd(3'd1, lo);  check("R6 low from snapshot", lo, 32'h0);
        rd(3'd2, hi);  check("R6 high from snapshot", hi, 32'h0);
        rd(3'd0, f);
        rd(3'd1, lo);  check("R6 new snapshot", lo, 32'd40);

        // R7: staging has no effect until high word written
        load_time(40'd0, 32'h0);
        wr(3'd0, 32'd5);
        wr(3'd1, 32'd1000);
        run_ticks(2);
        read_time(f, lo, hi);
        check("R7 staged residue not applied", f, 32'h0);
        check("R7 staged low not applied", lo, 32'd16);
        wr(3'd2, 32'h12);
        read_time(f, lo, hi);
        check("R7 commit residue", f, 32'd5);
        check("R7 commit low", lo, 32'd1000);
        check("R7 commit high", hi, 32'h12);

        // R4: only 8 high bits stored, upper read zero
        load_time(40'd0, 32'h0);
        wr(3'd2, 32'hFFFFFFFF);
        read_time(f, lo, hi);
        check("R4 high width", hi, 32'h000000FF);

        // R9: same-cycle tick uses old trim
        wr(3'd3, 32'h0);
        load_time(40'd0, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h40000000; tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        tick = 1'b0;
        read_time(f, lo, hi);
        check("R9 one tick with new trim", f, 32'h40000000);
        check("R9 two ticks elapsed", lo, 32'd16);

        // R8: halting mid-run freezes count
        wr(3'd4, 32'h80000000);
        run_ticks(4);
        read_time(f, lo, hi);
        check("R8 halted residue", f, 32'h40000000);
        check("R8 halted low", lo, 32'd16);
        wr(3'd4, 32'h0);

        // R10: reset mid-run
        run_ticks(3);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd(3'd3, d);  check("R10 rate cleared", d, 32'h0);
        rd(3'd4, d);  check("R10 halt set again", d, 32'h80000000);
        read_time(f, lo, hi);
        check("R10 low cleared", lo, 32'h0);
        check("R10 residue cleared", f, 32'h0);

        finish_run();
    end
endmodule